// File: doc/BRIEF.md
# Static Memory Strobe Timing Engine

This block runs one access at a time on an external asynchronous static memory bus. An internal requester raises `req` with direction, address, write data and byte enables, and holds them until `ack`. The engine then holds the address for a programmed number of bus cycles. During that time it places the chip-select, read-strobe and write-strobe low-going pulses. Each pulse has its own setup and width in clock cycles. The engine also drives the data-output enable for writes and captures read data on a selectable edge. All timing, width, lane-style, wait and float settings come from static configuration ports, which are meant to change only while the engine is idle.

The sequencer has three states: `ST_IDLE`, `ST_BUSY` and `ST_DONE`. The transitions are:

- **take** (`ST_IDLE` to `ST_BUSY`): a request is accepted.
- **step**: the cycle index advances inside `ST_BUSY`.
- **hold**: the cycle index is held by the wait input.
- **finish** (`ST_BUSY` to `ST_DONE`): the last bus cycle advances.
- **release** (`ST_DONE` to `ST_IDLE`): always taken after one cycle.

After a read, a turnaround counter blocks any access that would drive the bus until the memory has released the data lines.

Top module: `smem_strobe_seq`

## Requirements
- R1: While reset is asserted, all strobes and byte selects are high, `ack` and `mem_doe` are 0, and `rdata` is 0.
- R2: A request is taken only in `ST_IDLE`, and only when the turnaround counter is zero, except in the case R11 allows. The first bus cycle (index 0) follows the accepting clock edge. The requester drops `req` in the `ack` cycle.
- R3: Each strobe is low exactly in the cycles whose index i satisfies setup ≤ i < setup+pulse. The strobes are: chip-select (read or write settings), read strobe and write strobe. A strobe that would extend past the final bus cycle is cut off there.
- R4: The access lasts N bus cycles, where N is the read or write cycle count and a count of 0 means 1. `mem_addr` is stable throughout the access. `ack` is high for exactly one cycle, right after the last bus cycle.
- R5: The read-capture select chooses the edge. At 1, `rdata` holds `mem_din` as sampled at the clock edge where the read strobe's last low cycle ends. At 0, the same applies to the read chip-select. `rdata` is cleared when a new access is taken and is valid with `ack`.
- R6: On writes, `mem_doe` rises at the cycle where the selected signal falls and stays high to the end of the access. The write-drive select chooses the signal: 1 means the write strobe and 0 means the write chip-select. `mem_doe` is never high on reads.
- R7: The wait mode field sets how `mem_wait` is used. Codes 0 and 1 ignore it. Code 2 freezes the cycle index, and so every strobe, while it is high. Code 3 holds the cycle index at the last low cycle of the read or write strobe while it is high.
- R8: The lane style select sets how byte lanes are driven. At 0, `mem_wr_n[0]` carries the single shared write strobe and the other write lines stay high. In that style, `mem_bsel_n[i]` is low for the whole access for every selected lane. At 1, each selected lane's `mem_wr_n[i]` carries the write strobe and `mem_bsel_n` stays high. In both styles, the read strobe is shared.
- R9: The width code sets the active lanes: 0 gives 1 lane, 1 gives 2 lanes, and 2 or 3 give 4 lanes. A lane is selected when it is active, and on writes only when its `req_be` bit is also set.
- R10: The last bus cycle of a read loads the turnaround counter with float+1. The counter then counts down once per clock. So a write requested during the read's `ack` cycle is taken float+2 clock edges later.
- R11: When the float-skip bit is 1, a read request is taken while the turnaround counter is still running. Writes always wait for the counter to reach zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | LANES | Byte enables for writes |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | LANES | Write strobe(s), active low |
| mem_bsel_n | output | LANES | Byte selects, active low |
| mem_dout | output | DW | Write data to memory |
| mem_doe | output | 1 | Data-output enable |
| mem_din | input | DW | Read data from memory |
| mem_wait | input | 1 | Memory wait request, active high |
| cfg_cs_rd_setup | input | CW | Read chip-select setup |
| cfg_rd_setup | input | CW | Read strobe setup |
| cfg_cs_wr_setup | input | CW | Write chip-select setup |
| cfg_wr_setup | input | CW | Write strobe setup |
| cfg_cs_rd_pulse | input | CW | Read chip-select width |
| cfg_rd_pulse | input | CW | Read strobe width |
| cfg_cs_wr_pulse | input | CW | Write chip-select width |
| cfg_wr_pulse | input | CW | Write strobe width |
| cfg_rd_cycle | input | CW | Read access length |
| cfg_wr_cycle | input | CW | Write access length |
| cfg_width | input | 2 | Bus width code |
| cfg_rd_on_strobe | input | 1 | Read capture edge select |
| cfg_wr_on_strobe | input | 1 | Write drive edge select |
| cfg_wait_mode | input | 2 | Wait input mode |
| cfg_lane_strobes | input | 1 | Lane style select |
| cfg_float | input | FW | Turnaround count |
| cfg_float_skip | input | 1 | Turnaround skip for reads |

## Verification
The assertions assume several things about the environment:

- The configuration ports hold still from one clock edge to the next during an access. The frozen-wait check compares strobe levels across cycles, so it depends on this.
- The requester keeps `req_we` steady while `req` is high.

The bench changes configuration only in idle gaps or in the `ack` cycle, and it drops `req` in that cycle. The wait input is driven either as a held level or as a pseudo-random per-cycle pattern. It always returns low, so ready mode cannot stall forever.

// File: rtl/smem_pkg.sv
package smem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    localparam logic [1:0] WAIT_OFF    = 2'd0;
    localparam logic [1:0] WAIT_RSV    = 2'd1;
    localparam logic [1:0] WAIT_FREEZE = 2'd2;
    localparam logic [1:0] WAIT_READY  = 2'd3;

    // index of each strobe window in the window array
    localparam int WIN_CS_RD = 0;
    localparam int WIN_RD    = 1;
    localparam int WIN_CS_WR = 2;
    localparam int WIN_WR    = 3;
    localparam int WIN_COUNT = 4;
endpackage

// File: rtl/smem_win.sv
// Decodes one strobe window from the running cycle index.
module smem_win #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] t,
    input  logic [CW-1:0] setup,
    input  logic [CW-1:0] pulse,
    input  logic [CW:0]   total,
    output logic          act,
    output logic          last
);
    logic [CW:0] tx;
    logic [CW:0] tnext;
    logic [CW:0] endx;

    always_comb begin
        tx    = {1'b0, t};
        tnext = tx + 1'b1;
        endx  = {1'b0, setup} + {1'b0, pulse};
        act   = (tx >= {1'b0, setup}) && (tx < endx) && (tx < total);
        last  = act && ((tnext == endx) || (tnext == total));
    end
endmodule

// File: rtl/smem_float.sv
// Turnaround counter: loaded with span+1, counts down to zero.
module smem_float #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] span,
    output logic          busy
);
    logic [FW:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= {1'b0, span} + 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R10
    float_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/smem_strobe_seq.sv
module smem_strobe_seq
    import smem_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 24,
    parameter int CW    = 8,
    parameter int FW    = 4,
    localparam int DW   = 8 * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_be,
    output logic             ack,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_cs_n,
    output logic             mem_rd_n,
    output logic [LANES-1:0] mem_wr_n,
    output logic [LANES-1:0] mem_bsel_n,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_doe,
    input  logic [DW-1:0]    mem_din,
    input  logic             mem_wait,
    input  logic [CW-1:0]    cfg_cs_rd_setup,
    input  logic [CW-1:0]    cfg_rd_setup,
    input  logic [CW-1:0]    cfg_cs_wr_setup,
    input  logic [CW-1:0]    cfg_wr_setup,
    input  logic [CW-1:0]    cfg_cs_rd_pulse,
    input  logic [CW-1:0]    cfg_rd_pulse,
    input  logic [CW-1:0]    cfg_cs_wr_pulse,
    input  logic [CW-1:0]    cfg_wr_pulse,
    input  logic [CW-1:0]    cfg_rd_cycle,
    input  logic [CW-1:0]    cfg_wr_cycle,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_rd_on_strobe,
    input  logic             cfg_wr_on_strobe,
    input  logic [1:0]       cfg_wait_mode,
    input  logic             cfg_lane_strobes,
    input  logic [FW-1:0]    cfg_float,
    input  logic             cfg_float_skip
);
    seq_state_t st_q, st_d;

    logic [CW-1:0]    t_q;
    logic             we_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [LANES-1:0] be_q;
    logic [DW-1:0]    rdata_q;

    logic [WIN_COUNT*CW-1:0] setup_pk;
    logic [WIN_COUNT*CW-1:0] pulse_pk;
    logic [WIN_COUNT-1:0]    win_act;
    logic [WIN_COUNT-1:0]    win_last;

    logic [CW-1:0] cyc_sel;
    logic [CW:0]   tot_x;
    logic          busy, flt_busy, accept, hold, adv, end_acc, cap_edge;
    logic          wr_on;
    logic [CW-1:0] drive_setup;
    logic [LANES-1:0] lane_on, lane_sel;
    int            n_lanes;

    assign setup_pk = {cfg_wr_setup, cfg_cs_wr_setup, cfg_rd_setup, cfg_cs_rd_setup};
    assign pulse_pk = {cfg_wr_pulse, cfg_cs_wr_pulse, cfg_rd_pulse, cfg_cs_rd_pulse};
    assign cyc_sel  = we_q ? cfg_wr_cycle : cfg_rd_cycle;
    assign tot_x    = (cyc_sel == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, cyc_sel};

    for (genvar g = 0; g < WIN_COUNT; g++) begin : g_win
        smem_win #(.CW(CW)) u_win (
            .t     (t_q),
            .setup (setup_pk[g*CW +: CW]),
            .pulse (pulse_pk[g*CW +: CW]),
            .total (tot_x),
            .act   (win_act[g]),
            .last  (win_last[g])
        );
    end

    smem_float #(.FW(FW)) u_float (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (end_acc && !we_q),
        .span  (cfg_float),
        .busy  (flt_busy)
    );

    // handshake and cycle-index control
    always_comb begin
        busy   = (st_q == ST_BUSY);
        accept = (st_q == ST_IDLE) && req && (!flt_busy || (cfg_float_skip && !req_we));
        hold   = mem_wait && ((cfg_wait_mode == WAIT_FREEZE) ||
                 ((cfg_wait_mode == WAIT_READY) && (we_q ? win_last[WIN_WR] : win_last[WIN_RD])));
        adv      = busy && !hold;
        end_acc  = adv && (({1'b0, t_q} + 1'b1) == tot_x);
        cap_edge = adv && !we_q &&
                   (cfg_rd_on_strobe ? win_last[WIN_RD] : win_last[WIN_CS_RD]);
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept)  st_d = ST_BUSY;   // take
            ST_BUSY: if (end_acc) st_d = ST_DONE;   // finish (else step/hold)
            ST_DONE:              st_d = ST_IDLE;   // release
            default:              st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // access registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q     <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            t_q     <= '0;
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            rdata_q <= '0;
        end else if (adv) begin
            if (!end_acc) t_q <= t_q + 1'b1;
            if (cap_edge) rdata_q <= mem_din;
        end
    end

    // outputs
    always_comb begin
        unique case (cfg_width)
            2'd0:    n_lanes = 1;
            2'd1:    n_lanes = 2;
            default: n_lanes = 4;
        endcase
        lane_on = '0;
        for (int i = 0; i < LANES; i++)
            if (i < n_lanes) lane_on[i] = 1'b1;
        lane_sel    = lane_on & (we_q ? be_q : {LANES{1'b1}});
        wr_on       = busy && we_q && win_act[WIN_WR];
        drive_setup = cfg_wr_on_strobe ? cfg_wr_setup : cfg_cs_wr_setup;

        mem_cs_n = !(busy && (we_q ? win_act[WIN_CS_WR] : win_act[WIN_CS_RD]));
        mem_rd_n = !(busy && !we_q && win_act[WIN_RD]);
        if (cfg_lane_strobes) begin
            mem_wr_n   = wr_on ? ~lane_sel : {LANES{1'b1}};
            mem_bsel_n = {LANES{1'b1}};
        end else begin
            mem_wr_n    = {LANES{1'b1}};
            mem_wr_n[0] = !wr_on;
            mem_bsel_n  = busy ? ~lane_sel : {LANES{1'b1}};
        end
        mem_doe  = busy && we_q && (t_q >= drive_setup);
        mem_addr = addr_q;
        mem_dout = wdata_q;
        ack      = (st_q == ST_DONE);
        rdata    = rdata_q;
    end

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_addr));
    // R2
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && (st_d == ST_BUSY) && req_we) |-> !flt_busy);
    // R6
    doe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> (mem_rd_n && busy));
    // R8
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !(&mem_wr_n)));
    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_wait && (cfg_wait_mode == WAIT_FREEZE))
        |=> $stable({mem_cs_n, mem_rd_n, mem_wr_n, mem_bsel_n, mem_doe}));
endmodule

// File: tb/tb_smem_strobe_seq.sv
module tb_smem_strobe_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic req = 0, req_we = 0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic ack, mem_cs_n, mem_rd_n, mem_doe;
    logic [31:0] rdata, mem_dout;
    logic [31:0] mem_din = '0;
    logic mem_wait = 0;
    logic [23:0] mem_addr;
    logic [3:0]  mem_wr_n, mem_bsel_n;
    logic [7:0] c_crs = 1, c_rs = 2, c_cws = 0, c_ws = 1;
    logic [7:0] c_crp = 5, c_rp = 3, c_cwp = 6, c_wp = 4;
    logic [7:0] c_rc = 7, c_wc = 7;
    logic [1:0] c_width = 2, c_wm = 0;
    logic c_rds = 1, c_wrs = 1, c_lane = 0, c_fskip = 0;
    logic [3:0] c_flt = 2;

    smem_strobe_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_bsel_n(mem_bsel_n), .mem_dout(mem_dout),
        .mem_doe(mem_doe), .mem_din(mem_din), .mem_wait(mem_wait),
        .cfg_cs_rd_setup(c_crs), .cfg_rd_setup(c_rs), .cfg_cs_wr_setup(c_cws),
        .cfg_wr_setup(c_ws), .cfg_cs_rd_pulse(c_crp), .cfg_rd_pulse(c_rp),
        .cfg_cs_wr_pulse(c_cwp), .cfg_wr_pulse(c_wp), .cfg_rd_cycle(c_rc),
        .cfg_wr_cycle(c_wc), .cfg_width(c_width), .cfg_rd_on_strobe(c_rds),
        .cfg_wr_on_strobe(c_wrs), .cfg_wait_mode(c_wm), .cfg_lane_strobes(c_lane),
        .cfg_float(c_flt), .cfg_float_skip(c_fskip)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    int cyc = 0;
    bit wait_force = 0, wait_toggle = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory-side stimulus: data changes every cycle, wait forced or pseudo-random
    always @(negedge clk) begin
        #2;
        mem_din  <= 32'hA5000000 ^ (cyc * 32'h01030507);
        mem_wait <= wait_force | (wait_toggle && (((cyc * 7) % 5) < 2));
    end

    // ---------------- behavioural reference ----------------
    int m_st = 0, m_t = 0, m_flt = 0;
    bit m_we = 0;
    logic [23:0] m_addr = '0;
    logic [31:0] m_wd = '0, m_rd = '0;
    logic [3:0]  m_be = '0;

    function automatic int tot_of(bit w);
        int v = w ? int'(c_wc) : int'(c_rc);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic bit inwin(int s, int p, int t, int tot);
        return (t >= s) && (t < s + p) && (t < tot);
    endfunction
    function automatic bit lastwin(int s, int p, int t, int tot);
        return inwin(s, p, t, tot) && ((t == s + p - 1) || (t == tot - 1));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_flt = 0; m_we = 0;
            m_addr = '0; m_wd = '0; m_rd = '0; m_be = '0;
        end else begin
            int nflt;
            int tot;
            bit stall;
            nflt = (m_flt > 0) ? m_flt - 1 : 0;
            tot = tot_of(m_we);
            if (m_st == 0) begin
                if (req && (m_flt == 0 || (c_fskip && !req_we))) begin
                    m_we = req_we; m_addr = req_addr; m_wd = req_wdata; m_be = req_be;
                    m_rd = '0; m_t = 0; m_st = 1;
                end
                m_flt = nflt;
            end else if (m_st == 1) begin
                stall = mem_wait && ((c_wm == 2) || ((c_wm == 3) &&
                        (m_we ? lastwin(c_ws, c_wp, m_t, tot) : lastwin(c_rs, c_rp, m_t, tot))));
                m_flt = nflt;
                if (!stall) begin
                    if (!m_we && (c_rds ? lastwin(c_rs, c_rp, m_t, tot) : lastwin(c_crs, c_crp, m_t, tot)))
                        m_rd = mem_din;
                    if (m_t == tot - 1) begin
                        m_st = 2;
                        if (!m_we) m_flt = c_flt + 1;
                    end else m_t++;
                end
            end else begin
                m_st = 0;
                m_flt = nflt;
            end
        end
    end

    // per-cycle comparison and activity counters
    int cnt_rd = 0, cnt_cs = 0, cnt_doe = 0, cnt_bsel = 0;
    logic [3:0] last_bsel = '0, last_wr = '0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit busy, won;
            int tot, nb;
            logic e_cs, e_rd, e_doe;
            logic [3:0] lm, sel, e_wr, e_bs;
            busy = (m_st == 1);
            tot = tot_of(m_we);
            e_cs = !(busy && (m_we ? inwin(c_cws, c_cwp, m_t, tot) : inwin(c_crs, c_crp, m_t, tot)));
            e_rd = !(busy && !m_we && inwin(c_rs, c_rp, m_t, tot));
            won  = busy && m_we && inwin(c_ws, c_wp, m_t, tot);
            nb = (c_width == 0) ? 1 : (c_width == 1) ? 2 : 4;
            lm = 4'((1 << nb) - 1);
            sel = lm & (m_we ? m_be : 4'hF);
            if (!c_lane) begin
                e_wr = 4'hF; e_wr[0] = !won;
                e_bs = busy ? ~sel : 4'hF;
            end else begin
                e_wr = won ? ~sel : 4'hF;
                e_bs = 4'hF;
            end
            e_doe = busy && m_we && (m_t >= int'(c_wrs ? c_ws : c_cws));
            chk(mem_cs_n == e_cs, "R3 cs strobe", 32'(mem_cs_n), 32'(e_cs));
            chk(mem_rd_n == e_rd, "R3 read strobe", 32'(mem_rd_n), 32'(e_rd));
            chk(mem_wr_n == e_wr, "R8 write strobes", 32'(mem_wr_n), 32'(e_wr));
            chk(mem_bsel_n == e_bs, "R9 byte selects", 32'(mem_bsel_n), 32'(e_bs));
            chk(mem_doe == e_doe, "R6 data enable", 32'(mem_doe), 32'(e_doe));
            chk(ack == (m_st == 2), "R4 ack", 32'(ack), 32'(m_st == 2));
            chk(rdata == m_rd, "R5 read data", rdata, m_rd);
            chk(mem_addr == m_addr, "R4 address", 32'(mem_addr), 32'(m_addr));
            chk(mem_dout == m_wd, "R6 write data", mem_dout, m_wd);
            if (!mem_rd_n) cnt_rd++;
            if (!mem_cs_n) cnt_cs++;
            if (mem_doe) cnt_doe++;
            if (mem_bsel_n != 4'hF) begin cnt_bsel++; last_bsel = ~mem_bsel_n; end
            if (mem_wr_n != 4'hF) last_wr = ~mem_wr_n;
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit w, input logic [23:0] a, input logic [31:0] d,
                          input logic [3:0] be, output int lat);
        req_we = w; req_addr = a; req_wdata = d; req_be = be; req = 1; lat = 0;
        do begin @(negedge clk); lat++; end while (!ack && lat < 3000);
        #1 req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL R4 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int lat, c0, c1;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(ack == 0 && mem_doe == 0, "R1 ack/doe in reset", {ack, mem_doe}, 0);
        chk(mem_cs_n && mem_rd_n, "R1 cs/rd high in reset", {mem_cs_n, mem_rd_n}, 3);
        chk(mem_wr_n == 4'hF && mem_bsel_n == 4'hF, "R1 lanes high in reset", {mem_wr_n, mem_bsel_n}, 8'hFF);
        chk(rdata == 0, "R1 rdata in reset", rdata, 0);
        #1 rst_n = 1;
        idle(2);

        // basic read: R3 window widths, R4 length
        c0 = cnt_rd; c1 = cnt_cs;
        access(0, 24'h001234, 0, 4'h0, lat);
        chk(lat == 8, "R4 read latency", lat, 8);
        chk(cnt_rd - c0 == 3, "R3 read strobe width", cnt_rd - c0, 3);
        chk(cnt_cs - c1 == 5, "R3 read cs width", cnt_cs - c1, 5);
        idle(6);

        // write, shared strobe style with byte selects: R6 R8
        c0 = cnt_doe;
        access(1, 24'h000200, 32'hCAFEF00D, 4'b0101, lat);
        chk(lat == 8, "R4 write latency", lat, 8);
        chk(cnt_doe - c0 == 6, "R6 doe from write strobe", cnt_doe - c0, 6);
        chk(last_bsel == 4'b0101, "R8 byte selects shared style", last_bsel, 4'b0101);
        chk(last_wr == 4'b0001, "R8 single shared write strobe", last_wr, 4'b0001);
        idle(2);

        // per-lane write strobes, 2-byte width: R8 R9
        c_lane = 1; c_width = 1;
        c0 = cnt_bsel;
        access(1, 24'h000300, 32'h11223344, 4'hF, lat);
        chk(last_wr == 4'b0011, "R9 two active lanes", last_wr, 4'b0011);
        chk(cnt_bsel - c0 == 0, "R8 no byte selects in lane style", cnt_bsel - c0, 0);
        c_width = 0;
        access(1, 24'h000304, 32'h55667788, 4'hF, lat);
        chk(last_wr == 4'b0001, "R9 one active lane", last_wr, 4'b0001);
        c_width = 3;

        // drive from chip-select edge: R6
        c_wrs = 0; c0 = cnt_doe;
        access(1, 24'h000308, 32'h99AABBCC, 4'hF, lat);
        chk(cnt_doe - c0 == 7, "R6 doe from cs edge", cnt_doe - c0, 7);
        c_wrs = 1; c_lane = 0;
        idle(2);

        // clipped strobe R3, capture edges R5
        c_rs = 5; c_rp = 6; c0 = cnt_rd;
        access(0, 24'h000400, 0, 0, lat);
        chk(cnt_rd - c0 == 2, "R3 strobe clipped at cycle end", cnt_rd - c0, 2);
        chk(rdata == m_rd && rdata != 0, "R5 capture at read strobe", rdata, m_rd);
        idle(6);
        c_rds = 0; c_crs = 1; c_crp = 3;
        access(0, 24'h000404, 0, 0, lat);
        chk(rdata == m_rd && rdata != 0, "R5 capture at cs rise", rdata, m_rd);
        c_rds = 1; c_crp = 5; c_rs = 2; c_rp = 3;
        idle(6);

        // zero cycle count: R4
        c_rc = 0; c_rs = 0; c_rp = 1; c_crs = 0; c0 = cnt_rd;
        access(0, 24'h000500, 0, 0, lat);
        chk(lat == 2, "R4 zero cycle count means one", lat, 2);
        chk(cnt_rd - c0 == 1, "R3 single-cycle strobe", cnt_rd - c0, 1);
        c_rc = 7; c_rs = 2; c_rp = 3; c_crs = 1;
        idle(6);

        // turnaround: R2 R10 R11
        c_flt = 3; c_fskip = 0;
        access(0, 24'h000600, 0, 0, lat);
        access(1, 24'h000604, 32'h01020304, 4'hF, lat);
        chk(lat == 3 + 2 + 7, "R10 write waits float+1", lat, 12);
        idle(1);
        access(0, 24'h000608, 0, 0, lat);
        access(0, 24'h00060C, 0, 0, lat);
        chk(lat == 3 + 2 + 7, "R2 read held during float", lat, 12);
        c_fskip = 1;
        access(0, 24'h000610, 0, 0, lat);
        chk(lat == 2 + 7, "R11 read skips float", lat, 9);
        access(1, 24'h000614, 32'h0A0B0C0D, 4'hF, lat);
        chk(lat == 3 + 2 + 7, "R11 write still waits", lat, 12);
        c_fskip = 0; c_flt = 0;
        idle(4);

        // wait modes: R7
        wait_toggle = 1;
        c_wm = 1;
        access(0, 24'h000700, 0, 0, lat);
        chk(lat == 8, "R7 reserved mode ignores wait", lat, 8);
        idle(2);
        c_wm = 0;
        access(1, 24'h000704, 32'h13579BDF, 4'hF, lat);
        chk(lat == 8, "R7 disabled mode ignores wait", lat, 8);
        wait_toggle = 0;
        idle(2);
        // frozen: wait held for the first six cycles
        c_wm = 2; wait_force = 1;
        req_we = 0; req_addr = 24'h000708; req = 1;
        @(negedge clk); lat = 1; #1 req = 0;
        repeat (5) begin @(negedge clk); lat++; chk(!ack, "R7 frozen no ack", ack, 0); end
        #1 wait_force = 0;
        while (!ack && lat < 3000) begin @(negedge clk); lat++; end
        chk(lat == 6 + 7, "R7 frozen stretches access", lat, 13);
        idle(2);
        // ready: wait held for eight cycles, stall at last read pulse cycle
        c_wm = 3; c_rs = 2; c_rp = 2; wait_force = 1;
        req_we = 0; req_addr = 24'h00070C; req = 1;
        @(negedge clk); lat = 1; #1 req = 0;
        repeat (7) begin @(negedge clk); lat++; end
        #1 wait_force = 0;
        while (!ack && lat < 3000) begin @(negedge clk); lat++; end
        chk(lat == 7 + 1 + 8 - 4, "R7 ready holds pulse end", lat, 12);
        idle(2);

        // mixed traffic against the reference model
        wait_toggle = 1;
        for (int k = 0; k < 60; k++) begin
            c_crs = 8'($urandom_range(0, 4)); c_crp = 8'($urandom_range(0, 6));
            c_rs  = 8'($urandom_range(0, 4)); c_rp  = 8'($urandom_range(0, 6));
            c_cws = 8'($urandom_range(0, 4)); c_cwp = 8'($urandom_range(0, 6));
            c_ws  = 8'($urandom_range(0, 4)); c_wp  = 8'($urandom_range(0, 6));
            c_rc  = 8'($urandom_range(0, 10)); c_wc = 8'($urandom_range(0, 10));
            c_width = 2'($urandom_range(0, 3)); c_wm = 2'($urandom_range(0, 3));
            c_rds = 1'($urandom_range(0, 1)); c_wrs = 1'($urandom_range(0, 1));
            c_lane = 1'($urandom_range(0, 1)); c_fskip = 1'($urandom_range(0, 1));
            c_flt = 4'($urandom_range(0, 5));
            access(1'($urandom_range(0, 1)), 24'($urandom), $urandom, 4'($urandom), lat);
        end
        wait_toggle = 0;
        idle(4);

        finished = 1;
        summary();
        $finish;
    end
endmodule